// File: doc/BRIEF.md
# Codec Power-Management Register

This block is the power-management register of an audio codec. It sits on a simple register write/read port at index 26h. It stores one powerdown bit per section of the codec and drives a power-enable line to each section: ADC, DAC, analogue mixer, voltage reference, serial link and oscillator. It also reports a ready flag for each analogue section. A flag comes up only after a modelled settling interval has passed since that section was last switched back on.

Software normally powers the codec down one write at a time and switches the serial link off last. Once the link is off, the register accepts no further writes. Three events bring the link back:

- A pulse on the sync input (a warm reset) restarts the link and the oscillator and keeps every other stored bit.
- A cold reset clears the whole register.
- A hardware power-off pin, while it is low, forces every section off. When the pin is released, the device comes back fully active.

If software leaves the mixer bit clear while it sets all the others, the analogue path keeps playing while the rest of the device sleeps.

Top module: `pwr_ctl_reg`

## Requirements
- R1: After cold reset (rst_n low), read data bits 13:8 are 0, `sec_en_o` is 6'h3F and status bits 3:0 are 0.
- R2: A write to index 7'h26 loads the powerdown bits from write data bits 13:8, and `sec_en_o` becomes their inverse. The result is visible after the write clock edge. A write to any other index leaves the bits unchanged. Bit mapping, for both the powerdown bits and the enables: bit 0 ADC, bit 1 DAC, bit 2 mixer, bit 3 reference, bit 4 link, bit 5 oscillator.
- R3: Write data bits 15:14 and 7:0 have no effect. Read data bits 15:14 and 7:4 read 0.
- R4: Status bit 0 (ADC) follows powerdown bit 0, bit 1 (DAC) follows bit 1, bit 2 (analogue) follows bits 2 and 3 together, and bit 3 (reference) follows bit 3. A status bit reads 1 only when its bits are clear. It rises exactly SETTLE clock edges after the bits clear; the SETTLE values are 8 for ADC, 6 for DAC, 12 for analogue and 10 for reference.
- R5: A status bit reads 0 in the same cycle that its powerdown bit becomes set.
- R6: While powerdown bit 4 is set, register writes are ignored.
- R7: A rising edge on `sync_i` while bit 4 is set clears bits 4 and 5 at that clock edge and keeps bits 3:0.
- R8: A sync pulse while bit 4 is clear changes nothing.
- R9: While `pin_off_n` is low, bits 13:8 read 6'h3F, `sec_en_o` is 0, the status bits are 0 and writes are ignored.
- R10: After `pin_off_n` rises, the powerdown bits read 0, `sec_en_o` is 6'h3F, and the status bits rise after their SETTLE intervals.
- R11: With the mixer bit left clear and all other bits set, link bit last, the mixer enable stays 1 and all other enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| pin_off_n | input | 1 | Hardware power-off pin, active low |
| sync_i | input | 1 | Sync line; a rising edge is a warm reset while the link is off |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 7 | Register index |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for index 26h, 0 for any other index |
| sec_en_o | output | 6 | Section power enables: 0 ADC, 1 DAC, 2 mixer, 3 reference, 4 link, 5 oscillator |

## Verification
A powerdown bit stored wrongly shows at once as a wrong enable and as wrong read data in the cycle after the write or sync edge that set it. A settle counter that runs short or long shows as a status bit that comes up one or more cycles early or late. The bench therefore samples the ADC flag on both sides of its rising edge. A lock or wake path that fails shows only when the link is off, so the bench runs the full shut-down sequence and then probes that state with writes and with sync pulses.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int NUM_SEC  = 6;
    localparam int NUM_STAT = 4;
    localparam logic [6:0] REG_IDX = 7'h26;
    localparam int PD_LSB   = 8;

    typedef enum int {
        SEC_ADC  = 0,
        SEC_DAC  = 1,
        SEC_MIX  = 2,
        SEC_REF  = 3,
        SEC_LINK = 4,
        SEC_OSC  = 5
    } sec_e;

    typedef struct packed {
        logic [NUM_SEC-1:0] pd;
    } bits_state_t;
endpackage

// File: rtl/pwr_sync_edge.sv
module pwr_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic rise_o
);
    logic sync_d, sync_q;

    always_comb begin
        sync_d = sync_i;
        rise_o = sync_i & ~sync_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/pwr_settle.sv
module pwr_settle #(
    parameter int SETTLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_i,
    output logic rdy_o
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (off_i)              cnt_d = '0;
        else if (cnt_q == LIMIT) cnt_d = cnt_q;
        else                    cnt_d = cnt_q + 1'b1;
        rdy_o = !off_i && (cnt_q == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: a flag may only rise after a cycle with the section on
    p_rise_after_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(!off_i));
endmodule

// File: rtl/pwr_bits.sv
module pwr_bits
    import pwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_off_n,
    input  logic               wake_i,
    input  logic               wr_i,
    input  logic [NUM_SEC-1:0] wr_pd_i,
    output logic [NUM_SEC-1:0] pd_eff_o
);
    bits_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pin_off_n) begin
            st_d.pd = '0;
        end else if (st_q.pd[SEC_LINK]) begin
            if (wake_i) begin
                st_d.pd[SEC_LINK] = 1'b0;
                st_d.pd[SEC_OSC]  = 1'b0;
            end
        end else if (wr_i) begin
            st_d.pd = wr_pd_i;
        end
        pd_eff_o = pin_off_n ? st_q.pd : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: warm reset clears link and oscillator, keeps the rest
    p_warm_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_off_n && st_q.pd[SEC_LINK] && wake_i) |=>
        (!st_q.pd[SEC_LINK] && !st_q.pd[SEC_OSC] &&
         st_q.pd[3:0] == $past(st_q.pd[3:0])));

    // R6: link off and no wake means nothing changes
    p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_off_n && st_q.pd[SEC_LINK] && !wake_i) |=> $stable(st_q.pd));

    // R10: pin low leaves the stored bits clear for release
    p_pin_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_off_n |=> st_q.pd == '0);
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
    import pwr_pkg::*;
#(
    parameter int SETTLE_ADC = 8,
    parameter int SETTLE_DAC = 6,
    parameter int SETTLE_ANL = 12,
    parameter int SETTLE_REF = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_off_n,
    input  logic        sync_i,
    input  logic        bus_wr_i,
    input  logic [6:0]  bus_addr_i,
    input  logic [15:0] bus_wdata_i,
    output logic [15:0] bus_rdata_o,
    output logic [5:0]  sec_en_o
);
    logic                wake;
    logic                hit;
    logic [NUM_SEC-1:0]  pd_eff;
    logic [NUM_STAT-1:0] off_vec;
    logic [NUM_STAT-1:0] rdy_vec;
    logic                unused_wdata;

    assign hit          = (bus_addr_i == REG_IDX);
    assign unused_wdata = ^{bus_wdata_i[15:14], bus_wdata_i[7:0]};

    pwr_sync_edge u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .rise_o (wake)
    );

    pwr_bits u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_off_n (pin_off_n),
        .wake_i    (wake),
        .wr_i      (bus_wr_i && hit),
        .wr_pd_i   (bus_wdata_i[PD_LSB +: NUM_SEC]),
        .pd_eff_o  (pd_eff)
    );

    always_comb begin
        off_vec[0] = pd_eff[SEC_ADC];
        off_vec[1] = pd_eff[SEC_DAC];
        off_vec[2] = pd_eff[SEC_MIX] | pd_eff[SEC_REF];
        off_vec[3] = pd_eff[SEC_REF];
    end

    for (genvar i = 0; i < NUM_STAT; i++) begin : g_settle
        localparam int S = (i == 0) ? SETTLE_ADC :
                           (i == 1) ? SETTLE_DAC :
                           (i == 2) ? SETTLE_ANL : SETTLE_REF;
        pwr_settle #(.SETTLE(S)) u_settle (
            .clk   (clk),
            .rst_n (rst_n),
            .off_i (off_vec[i]),
            .rdy_o (rdy_vec[i])
        );
    end

    always_comb begin
        sec_en_o    = ~pd_eff;
        bus_rdata_o = '0;
        if (hit) begin
            bus_rdata_o[PD_LSB +: NUM_SEC] = pd_eff;
            bus_rdata_o[NUM_STAT-1:0]      = rdy_vec;
        end
    end

    // R9: pin low powers every section off and hides every ready flag
    p_pin_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_off_n |-> (sec_en_o == '0 && rdy_vec == '0));

    // R4: a ready flag implies its section is enabled
    p_rdy_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_vec[0] |-> sec_en_o[SEC_ADC]);

    // R5: setting a powerdown bit drops its flag in that cycle
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_en_o[SEC_DAC]) |-> !rdy_vec[1]);
endmodule

// File: tb/pwr_ctl_reg_bench.sv
module pwr_ctl_reg_bench;
    localparam int S_ADC = 8, S_DAC = 6, S_ANL = 12, S_REF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_off_n = 1'b1;
    logic        sync_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [6:0]  bus_addr_i = 7'h26;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic [5:0]  sec_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwr_ctl_reg #(.SETTLE_ADC(S_ADC), .SETTLE_DAC(S_DAC),
                  .SETTLE_ANL(S_ANL), .SETTLE_REF(S_REF)) u_pwr_ctl_reg (
        .clk(clk), .rst_n(rst_n), .pin_off_n(pin_off_n), .sync_i(sync_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .sec_en_o(sec_en_o)
    );

    // {addr, wdata, expected pd bits, expected enables}
    localparam logic [34:0] VECS [6] = '{
        {7'h26, 16'h0100, 6'h01, 6'h3E},
        {7'h26, 16'h0F00, 6'h0F, 6'h30},
        {7'h20, 16'h3F00, 6'h0F, 6'h30},
        {7'h26, 16'h000F, 6'h00, 6'h3F},
        {7'h26, 16'hC500, 6'h05, 6'h3A},
        {7'h26, 16'h0000, 6'h00, 6'h3F}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_addr_i = 7'h26;
        #1;
    endtask

    task automatic sync_pulse();
        @(negedge clk); sync_i = 1'b1;
        @(negedge clk); sync_i = 1'b0;
        #1;
    endtask

    function automatic logic [15:0] pdv(input logic [15:0] r);
        return {10'd0, r[13:8]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 pd", pdv(bus_rdata_o), 16'h0);
        chk("R1 en", {10'd0, sec_en_o}, 16'h3F);
        chk("R1 status", {12'd0, bus_rdata_o[3:0]}, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 vector walk
        for (int i = 0; i < 6; i++) begin
            wr(VECS[i][34:28], VECS[i][27:12]);
            chk("R2 pd", pdv(bus_rdata_o), {10'd0, VECS[i][11:6]});
            chk("R2 en", {10'd0, sec_en_o}, {10'd0, VECS[i][5:0]});
            chk("R3 zero fields", {bus_rdata_o[15:14], bus_rdata_o[7:4], 10'd0}, 16'h0);
        end

        // R4 ADC settle edge exactness
        wr(7'h26, 16'h0F00);
        wr(7'h26, 16'h0000);
        repeat (S_ADC - 1) @(negedge clk);
        #1 chk("R4 adc early", {15'd0, bus_rdata_o[0]}, 16'h0);
        @(negedge clk);
        #1 chk("R4 adc on time", {15'd0, bus_rdata_o[0]}, 16'h1);
        repeat (S_ANL) @(negedge clk);
        #1 chk("R4 all ready", {12'd0, bus_rdata_o[3:0]}, 16'hF);

        // R4 analogue tracks reference too; R5 drop same cycle
        wr(7'h26, 16'h0800);
        chk("R4 R5 ref off", {12'd0, bus_rdata_o[3:0]}, 16'h3);
        wr(7'h26, 16'h0200);
        chk("R5 dac drop", {12'd0, bus_rdata_o[3:0]}, 16'h1);
        wr(7'h26, 16'h0000);
        repeat (S_ANL + 1) @(negedge clk);
        #1 chk("R4 recover", {12'd0, bus_rdata_o[3:0]}, 16'hF);

        // R8 sync with link on
        wr(7'h26, 16'h0F00);
        sync_pulse();
        chk("R8 no effect", pdv(bus_rdata_o), 16'h0F);

        // R6 lock, R7 warm reset
        wr(7'h26, 16'h2F00);
        wr(7'h26, 16'h3F00);
        chk("R6 link off", {10'd0, sec_en_o}, 16'h0);
        wr(7'h26, 16'h0000);
        chk("R6 write ignored", pdv(bus_rdata_o), 16'h3F);
        sync_pulse();
        chk("R7 warm pd", pdv(bus_rdata_o), 16'h0F);
        chk("R7 warm en", {10'd0, sec_en_o}, 16'h30);

        // R11 mixer stays alive
        wr(7'h26, 16'h2B00);
        wr(7'h26, 16'h3B00);
        chk("R11 mixer alive", {10'd0, sec_en_o}, 16'h04);

        // R9 pin low, R10 release
        wr(7'h26, 16'h0000);
        sync_pulse();
        wr(7'h26, 16'h0000);
        repeat (S_ANL + 1) @(negedge clk);
        @(negedge clk); pin_off_n = 1'b0; #1;
        chk("R9 pd forced", pdv(bus_rdata_o), 16'h3F);
        chk("R9 en off", {10'd0, sec_en_o}, 16'h0);
        chk("R9 status", {12'd0, bus_rdata_o[3:0]}, 16'h0);
        wr(7'h26, 16'h0300);
        @(negedge clk); pin_off_n = 1'b1; #1;
        chk("R10 pd clear", pdv(bus_rdata_o), 16'h0);
        chk("R10 en", {10'd0, sec_en_o}, 16'h3F);
        chk("R10 status low", {12'd0, bus_rdata_o[3:0]}, 16'h0);
        repeat (S_ANL + 1) @(negedge clk);
        #1 chk("R10 status up", {12'd0, bus_rdata_o[3:0]}, 16'hF);

        // R1 cold reset after activity
        wr(7'h26, 16'h0500);
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R1 cold pd", pdv(bus_rdata_o), 16'h0);
        chk("R1 cold status", {12'd0, bus_rdata_o[3:0]}, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule